// File: doc/BRIEF.md
# Four-Channel Converter Double-Buffered Load Front End

This block is the digital side of a four-channel, 12-bit voltage converter. A host writes codes over a parallel bus into one staging register per channel. A separate transfer strobe then copies all four staging registers into the output registers on the same clock edge, so every analog channel changes together. The outputs are four 12-bit codes, packed into one vector, that drive the analog stage.

A host with a full-width bus writes a whole code in one strobe. A host with a byte-wide bus writes in two phases. First it sends the upper eight bits on the top bus pins with the width select high. Then it sends the lower four bits, also on the top four pins, with the width select low.

A clear line gives two behaviours. On its own, while it is low, the outputs show zero and the stored codes are kept. Combined with a transfer strobe, it resets the output registers to zero, and they stay zero after the line is released.

All control inputs are active low except the width select. They are sampled on the rising edge of a single clock.

Top module: `quad_dac_frontend`

## Requirements
- R1: Address value 0 selects channel 1, 1 selects channel 2, 2 selects channel 3 and 3 selects channel 4. Channel k (k = 1..4) appears on `dac_code[12*k-1 : 12*(k-1)]`.
- R2: A staging register is written only on a clock edge where `cs_n` and `wr1_n` are both low. If either of them is high, no staging register changes, whatever the other inputs do.
- R3: A write changes only the addressed channel's staging register.
- R4: A write with `byte_sel` = 1 stores `data_in[11:0]` in the addressed staging register. On a byte-wide bus, this puts pins 11..4 into the upper eight bits.
- R5: A write with `byte_sel` = 0 stores `data_in[11:8]` into bits 3..0 of the addressed staging register and leaves bits 11..4 unchanged.
- R6: On a clock edge where `xfer_n` and `wr2_n` are both low and `clr_n` is high, all four output registers take the staging values held just before that edge. This holds even when a write happens on the same edge.
- R7: Without a transfer (either `xfer_n` or `wr2_n` high), the output registers keep their values.
- R8: While `clr_n` is low, every output code reads zero with no clock delay. When `clr_n` returns high and no transfer has occurred, the stored codes are visible again.
- R9: A transfer edge with `clr_n` low resets all four output registers to 0x000. They stay at zero after `clr_n` is released.
- R10: A clock edge with `rst_n` low sets every staging and output register to 0x000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| data_in | input | 12 | Parallel data bus |
| addr | input | 2 | Channel select |
| cs_n | input | 1 | Chip select, active low |
| wr1_n | input | 1 | Staging write strobe, active low |
| byte_sel | input | 1 | 1: full-width or upper-byte write; 0: low-nibble write |
| wr2_n | input | 1 | Transfer strobe qualifier, active low |
| xfer_n | input | 1 | Transfer request, active low |
| clr_n | input | 1 | Clear, active low |
| dac_code | output | 48 | Four packed 12-bit output codes, channel 1 in the lowest bits |

## Verification
The bench builds the block with its default parameters: four channels, 12-bit codes and an 8-bit upper phase, which leaves a 4-bit low phase. With these values the nibble that the low phase writes on the top pins can be told apart from the bits that stay in place, so writing the two phases in their required order can be checked against the result. Four channels are enough to show that a write does not reach its neighbours. They also show whether one transfer edge moves every channel. Staging contents are observed only through transfers, so the hold rules for idle strobes and the half-asserted strobe pairs are checked at the outputs.

// File: rtl/qdac_pkg.sv
package qdac_pkg;
   // Width selection for a staging write
   typedef enum logic {
      PH_LOW_NIBBLE = 1'b0,
      PH_FULL       = 1'b1
   } load_phase_e;

   // Decoded control actions for one clock edge
   typedef struct packed {
      logic        wr_en;
      load_phase_e phase;
      logic        copy;
      logic        zero;
   } ctrl_s;
endpackage

// File: rtl/qdac_ctrl.sv
module qdac_ctrl
   import qdac_pkg::*;
(
   input  logic  cs_n,
   input  logic  wr1_n,
   input  logic  byte_sel,
   input  logic  wr2_n,
   input  logic  xfer_n,
   input  logic  clr_n,
   output ctrl_s ctrl
);
   logic xfer_req;

   always_comb begin
      xfer_req   = ~xfer_n & ~wr2_n;
      ctrl.wr_en = ~cs_n & ~wr1_n;
      ctrl.phase = byte_sel ? PH_FULL : PH_LOW_NIBBLE;
      ctrl.copy  = xfer_req & clr_n;
      ctrl.zero  = xfer_req & ~clr_n;
   end
endmodule

// File: rtl/qdac_stage_bank.sv
module qdac_stage_bank
   import qdac_pkg::*;
#(
   parameter int NUM_CH = 4,
   parameter int CODE_W = 12,
   parameter int HI_W   = 8,
   localparam int ADDR_W = $clog2(NUM_CH),
   localparam int LO_W   = CODE_W - HI_W
)(
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     wr_en,
   input  load_phase_e              phase,
   input  logic [ADDR_W-1:0]        wr_addr,
   input  logic [CODE_W-1:0]        wr_data,
   output logic [NUM_CH*CODE_W-1:0] stage_q
);
   for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
      logic [CODE_W-1:0] q;
      logic              hit;

      assign hit = wr_en && (wr_addr == ADDR_W'(ch));

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            q <= '0;
         end else if (hit) begin
            if (phase == PH_FULL) q <= wr_data;
            else                  q[LO_W-1:0] <= wr_data[CODE_W-1 -: LO_W];
         end
      end

      assign stage_q[ch*CODE_W +: CODE_W] = q;
   end
endmodule

// File: rtl/qdac_out_bank.sv
module qdac_out_bank #(
   parameter int NUM_CH = 4,
   parameter int CODE_W = 12
)(
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     copy,
   input  logic                     zero,
   input  logic [NUM_CH*CODE_W-1:0] stage_q,
   output logic [NUM_CH*CODE_W-1:0] out_q
);
   for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
      logic [CODE_W-1:0] q;

      always_ff @(posedge clk) begin
         if (!rst_n || zero) q <= '0;
         else if (copy)      q <= stage_q[ch*CODE_W +: CODE_W];
      end

      assign out_q[ch*CODE_W +: CODE_W] = q;
   end
endmodule

// File: rtl/qdac_blank.sv
module qdac_blank #(
   parameter int NUM_CH = 4,
   parameter int CODE_W = 12
)(
   input  logic                     clr_n,
   input  logic [NUM_CH*CODE_W-1:0] out_q,
   output logic [NUM_CH*CODE_W-1:0] code
);
   for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
      assign code[ch*CODE_W +: CODE_W] = clr_n ? out_q[ch*CODE_W +: CODE_W] : '0;
   end
endmodule

// File: rtl/quad_dac_frontend.sv
module quad_dac_frontend
   import qdac_pkg::*;
#(
   parameter int NUM_CH = 4,
   parameter int CODE_W = 12,
   parameter int HI_W   = 8,
   localparam int ADDR_W = $clog2(NUM_CH),
   localparam int LO_W   = CODE_W - HI_W
)(
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [CODE_W-1:0]        data_in,
   input  logic [ADDR_W-1:0]        addr,
   input  logic                     cs_n,
   input  logic                     wr1_n,
   input  logic                     byte_sel,
   input  logic                     wr2_n,
   input  logic                     xfer_n,
   input  logic                     clr_n,
   output logic [NUM_CH*CODE_W-1:0] dac_code
);
   if (NUM_CH < 2) begin : g_bad_ch
      $error("quad_dac_frontend: NUM_CH must be at least 2");
   end
   if (HI_W < 1 || HI_W >= CODE_W) begin : g_bad_hi
      $error("quad_dac_frontend: HI_W must lie in 1..CODE_W-1");
   end
   if (LO_W > HI_W) begin : g_bad_lo
      $error("quad_dac_frontend: low phase must fit on the upper pins");
   end

   ctrl_s                     ctrl;
   logic [NUM_CH*CODE_W-1:0]  stage_w;
   logic [NUM_CH*CODE_W-1:0]  outreg_w;

   qdac_ctrl u_ctrl (
      .cs_n     (cs_n),
      .wr1_n    (wr1_n),
      .byte_sel (byte_sel),
      .wr2_n    (wr2_n),
      .xfer_n   (xfer_n),
      .clr_n    (clr_n),
      .ctrl     (ctrl)
   );

   qdac_stage_bank #(.NUM_CH(NUM_CH), .CODE_W(CODE_W), .HI_W(HI_W)) u_stage (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (ctrl.wr_en),
      .phase   (ctrl.phase),
      .wr_addr (addr),
      .wr_data (data_in),
      .stage_q (stage_w)
   );

   qdac_out_bank #(.NUM_CH(NUM_CH), .CODE_W(CODE_W)) u_out (
      .clk     (clk),
      .rst_n   (rst_n),
      .copy    (ctrl.copy),
      .zero    (ctrl.zero),
      .stage_q (stage_w),
      .out_q   (outreg_w)
   );

   qdac_blank #(.NUM_CH(NUM_CH), .CODE_W(CODE_W)) u_blank (
      .clr_n (clr_n),
      .out_q (outreg_w),
      .code  (dac_code)
   );
endmodule

// File: rtl/qdac_checker.sv
module qdac_checker #(
   parameter int NUM_CH = 4,
   parameter int CODE_W = 12,
   parameter int HI_W   = 8,
   localparam int ADDR_W = $clog2(NUM_CH),
   localparam int LO_W   = CODE_W - HI_W
)(
   input logic                     clk,
   input logic                     rst_n,
   input logic [ADDR_W-1:0]        addr,
   input logic                     cs_n,
   input logic                     wr1_n,
   input logic                     byte_sel,
   input logic                     wr2_n,
   input logic                     xfer_n,
   input logic                     clr_n,
   input logic [NUM_CH*CODE_W-1:0] stage_q,
   input logic [NUM_CH*CODE_W-1:0] out_q,
   input logic [NUM_CH*CODE_W-1:0] dac_code
);
   logic wr_act, xf_act;
   assign wr_act = !cs_n && !wr1_n;
   assign xf_act = !xfer_n && !wr2_n;

   a_r2_idle_strobes_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_act |=> $stable(stage_q));

   a_r6_transfer_copies: assert property (@(posedge clk) disable iff (!rst_n)
      (xf_act && clr_n) |=> out_q == $past(stage_q));

   a_r7_no_transfer_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !xf_act |=> $stable(out_q));

   a_r8_clear_blanks: assert property (@(posedge clk) disable iff (!rst_n)
      !clr_n |-> dac_code == '0);

   a_r9_combined_reset: assert property (@(posedge clk) disable iff (!rst_n)
      (xf_act && !clr_n) |=> out_q == '0);

   for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
      a_r3_other_channel_hold: assert property (@(posedge clk) disable iff (!rst_n)
         (wr_act && addr != ADDR_W'(c)) |=> $stable(stage_q[c*CODE_W +: CODE_W]));

      a_r5_low_phase_keeps_upper: assert property (@(posedge clk) disable iff (!rst_n)
         (wr_act && !byte_sel && addr == ADDR_W'(c))
            |=> $stable(stage_q[c*CODE_W+LO_W +: HI_W]));
   end
endmodule

bind quad_dac_frontend qdac_checker #(.NUM_CH(NUM_CH), .CODE_W(CODE_W), .HI_W(HI_W)) u_qdac_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .addr     (addr),
   .cs_n     (cs_n),
   .wr1_n    (wr1_n),
   .byte_sel (byte_sel),
   .wr2_n    (wr2_n),
   .xfer_n   (xfer_n),
   .clr_n    (clr_n),
   .stage_q  (stage_w),
   .out_q    (outreg_w),
   .dac_code (dac_code)
);

// File: tb/quad_dac_frontend_bench.sv
module quad_dac_frontend_bench;
   localparam int NCH = 4;
   localparam int CW  = 12;

   logic          clk = 1'b0;
   logic          rst_n;
   logic [CW-1:0] data_in;
   logic [1:0]    addr;
   logic          cs_n, wr1_n, byte_sel, wr2_n, xfer_n, clr_n;
   logic [NCH*CW-1:0] dac_code;

   int    n_chk  = 0;
   int    n_fail = 0;
   string tag    = "R10";

   logic [CW-1:0] m_in  [NCH];
   logic [CW-1:0] m_dac [NCH];

   always #10 clk = ~clk;

   quad_dac_frontend u_quad_dac_frontend (
      .clk(clk), .rst_n(rst_n), .data_in(data_in), .addr(addr),
      .cs_n(cs_n), .wr1_n(wr1_n), .byte_sel(byte_sel), .wr2_n(wr2_n),
      .xfer_n(xfer_n), .clr_n(clr_n), .dac_code(dac_code)
   );

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
   endtask

   task automatic model_edge();
      bit xf = !xfer_n && !wr2_n;
      if (!rst_n) begin
         for (int c = 0; c < NCH; c++) begin
            m_in[c] = '0; m_dac[c] = '0;
         end
      end else begin
         if (xf) for (int c = 0; c < NCH; c++) m_dac[c] = clr_n ? m_in[c] : 12'h000;
         if (!cs_n && !wr1_n) begin
            if (byte_sel) m_in[addr] = data_in;
            else          m_in[addr] = {m_in[addr][11:4], data_in[11:8]};
         end
      end
   endtask

   task automatic compare();
      for (int c = 0; c < NCH; c++) begin
         logic [CW-1:0] exp_v = clr_n ? m_dac[c] : 12'h000;
         logic [CW-1:0] got_v = dac_code[c*CW +: CW];
         n_chk++;
         if (got_v !== exp_v) begin
            n_fail++;
            $display("FAIL %s ch%0d actual %h expected %h", tag, c + 1, got_v, exp_v);
         end
      end
   endtask

   task automatic tick();
      @(posedge clk);
      model_edge();
      @(negedge clk);
      compare();
   endtask

   task automatic idle();
      cs_n = 1; wr1_n = 1; wr2_n = 1; xfer_n = 1; clr_n = 1; byte_sel = 1;
   endtask

   task automatic write(input logic [1:0] a, input logic [CW-1:0] d, input logic bs);
      addr = a; data_in = d; byte_sel = bs; cs_n = 0; wr1_n = 0;
      tick();
      cs_n = 1; wr1_n = 1; data_in = 12'hFFF;
      tick();
   endtask

   task automatic transfer();
      xfer_n = 0; wr2_n = 0;
      tick();
      xfer_n = 1; wr2_n = 1;
      tick();
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
   end

   initial begin
      idle();
      rst_n = 0; data_in = '0; addr = '0;
      for (int c = 0; c < NCH; c++) begin
         m_in[c] = '0; m_dac[c] = '0;
      end
      // R10: reset state
      tag = "R10 reset";
      tick(); tick();
      rst_n = 1;
      tick();

      // R1 R3 R4 R6: distinct full-width codes per channel, one transfer
      tag = "R1 R3 R4 R6 full write";
      write(2'd0, 12'h123, 1'b1);
      write(2'd1, 12'h456, 1'b1);
      write(2'd2, 12'h789, 1'b1);
      write(2'd3, 12'hABC, 1'b1);
      tick();
      transfer();

      // R2: idle and half-asserted strobe pairs must not write
      tag = "R2 strobe inhibit";
      addr = 2'd1; data_in = 12'hEEE;
      cs_n = 1; wr1_n = 1; tick();
      cs_n = 0; wr1_n = 1; tick();
      cs_n = 1; wr1_n = 0; tick();
      idle();
      transfer();

      // R7: loads without a transfer leave outputs alone
      tag = "R7 hold";
      write(2'd0, 12'h5A5, 1'b1);
      write(2'd3, 12'h0F0, 1'b1);
      wr2_n = 0; tick(); wr2_n = 1;
      xfer_n = 0; tick(); xfer_n = 1;
      tick();
      tag = "R6 R7 later transfer";
      transfer();

      // R5: two-phase byte-wide load, upper first then low nibble
      tag = "R5 R4 two-phase";
      write(2'd2, 12'hAB5, 1'b1);
      write(2'd2, 12'h7C3, 1'b0);
      transfer();
      tag = "R5 low nibble only";
      write(2'd1, 12'h9FF, 1'b0);
      transfer();

      // R6: write and transfer on the same edge copies the older value
      tag = "R6 same-edge write";
      addr = 2'd0; data_in = 12'hDEF; byte_sel = 1; cs_n = 0; wr1_n = 0;
      xfer_n = 0; wr2_n = 0;
      tick();
      idle();
      tick();
      transfer();

      // R8: clear alone blanks, release restores
      tag = "R8 clear blank";
      clr_n = 0; tick(); tick();
      write(2'd3, 12'h321, 1'b1);
      clr_n = 1; tick();
      clr_n = 0; tick();
      tag = "R8 clear release";
      clr_n = 1; tick(); tick();

      // R9: clear with transfer resets outputs, persists after release
      tag = "R9 combined clear";
      clr_n = 0; xfer_n = 0; wr2_n = 0; tick();
      xfer_n = 1; wr2_n = 1; tick();
      clr_n = 1; tick(); tick();
      tag = "R9 R6 after clear";
      transfer();

      // R10: reset in mid-run clears both levels
      tag = "R10 mid reset";
      rst_n = 0; tick();
      rst_n = 1; tick();
      transfer();

      summary();
      $finish;
   end
endmodule